// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block drives the channel select and the conversion-start strobe of an external 8-channel, 12-bit converter. It stores every finished result in a sample FIFO that the host reads one byte at a time. A host register port chooses what the sequencer does. In single mode it converts one fixed channel. In scan mode it walks a fixed channel sequence, either upward from channel 0 or downward from a programmed top channel. In interval mode a scan tick starts a burst of a programmed length.

A conversion starts in one of two ways. When pacing is off, a software strobe write starts it. When pacing is on, the `conv_tick` input starts it. The host reads a status byte with data-available, half-full, overflow, overrun and busy bits, and it can enable an interrupt for each condition. The analog front end, gain and reference selection, and bulk transfer logic live outside this block.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the status byte (bit0 data-available, bit1 half-full, bit2 overflow, bit3 overrun, bit4 busy) reads 0, `irq` is low and no conversion starts.
- R2: A write to address 4 starts one conversion on the loaded channel only while pacing (mode bit1) and interval mode (mode bit2) are both clear. In any other case the write is ignored.
- R3: A write to address 0 with bit3 clear loads the top channel from bits[2:0], turns scanning off and arms the scan enable. A write with bit3 set turns scanning on only when armed, and its other bits are ignored. Without arming, that write has no effect.
- R4: With scanning on and mode bit0 set (up), conversions use channels 0,1,…,top and then wrap to 0.
- R5: With scanning on and mode bit0 clear (down), conversions use channels top, top-1,…,0 and then wrap to top.
- R6: With pacing on and interval mode off, every `conv_tick` that arrives while idle starts exactly one conversion.
- R7: In interval mode, `scan_tick` loads a burst of the active interval count. Each `conv_tick` then starts one conversion until the burst is spent, and further ticks start nothing.
- R8: A write to address 2 only stages the interval count. The count becomes active when address 3 is written.
- R9: Address 1 of the read port returns the oldest sample as two reads: low byte first, then {4'b0, bits[11:8]}. The sample leaves the FIFO on the second read.
- R10: Data-available is set while the FIFO holds a sample. Half-full is set while it holds at least half its depth (8 of 16).
- R11: A result that arrives while the FIFO is full is dropped and sets overflow, which stays set. A write to address 5 empties the FIFO and clears overflow and overrun.
- R12: A pacing tick that arrives while a conversion is busy sets overrun, which stays set until it is cleared, and the tick starts nothing.
- R13: `irq` is the OR of data-available gated by mode bit4, half-full gated by mode bit5, and (overflow or overrun) gated by mode bit6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register address: 0 channel, 1 mode, 2 interval stage, 3 interval strobe, 4 software start, 5 clear |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Host read strobe (advances the FIFO byte pointer) |
| rd_sel | input | 1 | Read select: 0 status, 1 FIFO data |
| rd_data | output | 8 | Read data for the current selection |
| conv_tick | input | 1 | Conversion pacing tick |
| scan_tick | input | 1 | Burst start tick for interval mode |
| adc_start | output | 1 | One-cycle conversion start to the converter |
| adc_chan | output | 3 | Channel of the current conversion |
| adc_done | input | 1 | Converter result valid |
| adc_data | input | 12 | Converter result |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. An accepted start appears on `adc_start` and `adc_chan` in the cycle after that edge. The bench converter model returns `adc_done` three cycles later, and the sample is in the FIFO after the next edge. Status and FIFO bytes are combinational reads of the state as it stands. The bench therefore spaces every tick or strobe eight cycles apart before it reads anything. It samples `rd_data` one time unit after it drives the select at the falling edge, so the value it reads comes before the pop that edge triggers.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam logic [2:0] A_CHAN   = 3'd0;
  localparam logic [2:0] A_MODE   = 3'd1;
  localparam logic [2:0] A_ICNT   = 3'd2;
  localparam logic [2:0] A_ISTB   = 3'd3;
  localparam logic [2:0] A_SWCONV = 3'd4;
  localparam logic [2:0] A_CLEAR  = 3'd5;
  localparam int SCAN_BIT = 3;

  typedef struct packed {
    logic err_ie;
    logic hf_ie;
    logic dav_ie;
    logic int_mode;
    logic pace_en;
    logic dir_up;
  } mode_t;

  function automatic mode_t decode_mode(input logic [7:0] d);
    mode_t m;
    m.dir_up   = d[0];
    m.pace_en  = d[1];
    m.int_mode = d[2];
    m.dav_ie   = d[4];
    m.hf_ie    = d[5];
    m.err_ie   = d[6];
    return m;
  endfunction
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int ICNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CH_W-1:0]   hi_chan,
  output logic              scan_en,
  output logic              scan_start,
  output logic              sw_conv,
  output logic              clr,
  output mode_t             mode,
  output logic [ICNT_W-1:0] icnt
);
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              scan_q, scan_d, arm_q, arm_d;
  mode_t             mode_q, mode_d;
  logic [ICNT_W-1:0] stg_q, stg_d, act_q, act_d;

  assign scan_start = wr_en && (wr_addr == A_CHAN) && wr_data[SCAN_BIT] && arm_q;
  assign sw_conv    = wr_en && (wr_addr == A_SWCONV);
  assign clr        = wr_en && (wr_addr == A_CLEAR);

  always_comb begin
    chan_d = chan_q;
    scan_d = scan_q;
    arm_d  = arm_q;
    mode_d = mode_q;
    stg_d  = stg_q;
    act_d  = act_q;
    if (wr_en) begin
      case (wr_addr)
        A_CHAN: begin
          if (!wr_data[SCAN_BIT]) begin
            chan_d = wr_data[CH_W-1:0];
            scan_d = 1'b0;
            arm_d  = 1'b1;
          end else if (arm_q) begin
            scan_d = 1'b1;
            arm_d  = 1'b0;
          end
        end
        A_MODE:  mode_d = decode_mode(wr_data);
        A_ICNT:  stg_d  = wr_data[ICNT_W-1:0];
        A_ISTB:  act_d  = stg_q;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      scan_q <= 1'b0;
      arm_q  <= 1'b0;
      mode_q <= '0;
      stg_q  <= '0;
      act_q  <= '0;
    end else begin
      chan_q <= chan_d;
      scan_q <= scan_d;
      arm_q  <= arm_d;
      mode_q <= mode_d;
      stg_q  <= stg_d;
      act_q  <= act_d;
    end
  end

  assign hi_chan = chan_q;
  assign scan_en = scan_q;
  assign mode    = mode_q;
  assign icnt    = act_q;
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int CH_W   = 3,
  parameter int ICNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_up,
  input  logic              pace_en,
  input  logic              int_mode,
  input  logic              scan_en,
  input  logic              scan_start,
  input  logic [CH_W-1:0]   hi_chan,
  input  logic [ICNT_W-1:0] icnt,
  input  logic              sw_conv,
  input  logic              clr,
  input  logic              conv_tick,
  input  logic              scan_tick,
  input  logic              adc_done,
  output logic              adc_start,
  output logic [CH_W-1:0]   adc_chan,
  output logic              busy,
  output logic              ovr,
  output logic              push
);
  logic              busy_q, busy_d, ovr_q, ovr_d, start_q, start_d;
  logic [CH_W-1:0]   cur_q, cur_d, chan_q, chan_d;
  logic [ICNT_W-1:0] burst_q, burst_d;
  logic              tick_req, sw_req, go;
  logic [CH_W-1:0]   this_chan;

  always_comb begin
    tick_req  = conv_tick && (int_mode ? (burst_q != '0) : pace_en);
    sw_req    = sw_conv && !int_mode && !pace_en;
    go        = (tick_req || sw_req) && !busy_q;
    this_chan = scan_en ? cur_q : hi_chan;

    cur_d = cur_q;
    if (scan_start) begin
      cur_d = dir_up ? '0 : hi_chan;
    end else if (go && scan_en) begin
      if (dir_up) cur_d = (cur_q == hi_chan) ? '0 : cur_q + 1'b1;
      else        cur_d = (cur_q == '0) ? hi_chan : cur_q - 1'b1;
    end

    burst_d = burst_q;
    if (scan_tick && int_mode)  burst_d = icnt;
    else if (go && int_mode)    burst_d = burst_q - 1'b1;

    busy_d = busy_q;
    if (go)            busy_d = 1'b1;
    else if (adc_done) busy_d = 1'b0;

    ovr_d   = clr ? 1'b0 : (ovr_q || (tick_req && busy_q));
    start_d = go;
    chan_d  = go ? this_chan : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ovr_q   <= 1'b0;
      start_q <= 1'b0;
      cur_q   <= '0;
      chan_q  <= '0;
      burst_q <= '0;
    end else begin
      busy_q  <= busy_d;
      ovr_q   <= ovr_d;
      start_q <= start_d;
      cur_q   <= cur_d;
      chan_q  <= chan_d;
      burst_q <= burst_d;
    end
  end

  assign adc_start = start_q;
  assign adc_chan  = chan_q;
  assign busy      = busy_q;
  assign ovr       = ovr_q;
  assign push      = adc_done && busy_q;
endmodule

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          rd_byte,
  input  logic          clr,
  output logic [7:0]    dout,
  output logic          dav,
  output logic          hf,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          ph_q, ph_d, ovf_q, ovf_d;
  logic          full, empty, do_push, do_pop;
  logic [15:0]   head;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = rd_byte && !empty && ph_q && !clr;
  assign head    = 16'(mem[rp_q]);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    ovf_d = ovf_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ph_d  = 1'b0;
      ovf_d = 1'b0;
    end else begin
      if (push && full) ovf_d = 1'b1;
      if (do_push) wp_d = wp_q + 1'b1;
      if (do_pop)  rp_d = rp_q + 1'b1;
      if (rd_byte && !empty) ph_d = !ph_q;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  assign dout = empty ? 8'h00 : (ph_q ? head[15:8] : head[7:0]);
  assign dav  = !empty;
  assign hf   = (cnt_q >= HALF_CNT);
  assign ovf  = ovf_q;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DW     = 12,
  parameter int DEPTH  = 16,
  parameter int ICNT_W = 8,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            rd_en,
  input  logic            rd_sel,
  output logic [7:0]      rd_data,
  input  logic            conv_tick,
  input  logic            scan_tick,
  output logic            adc_start,
  output logic [CH_W-1:0] adc_chan,
  input  logic            adc_done,
  input  logic [DW-1:0]   adc_data,
  output logic            irq
);
  logic [CH_W-1:0]   hi_chan_w;
  logic              scan_en_w, scan_start_w, sw_conv_w, clr_w;
  mode_t             mode_w;
  logic [ICNT_W-1:0] icnt_w;
  logic              busy_w, ovr_w, push_w;
  logic [7:0]        fifo_byte;
  logic              dav_w, hf_w, ovf_w;

  adc_scan_regs #(.CH_W(CH_W), .ICNT_W(ICNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hi_chan(hi_chan_w), .scan_en(scan_en_w), .scan_start(scan_start_w),
    .sw_conv(sw_conv_w), .clr(clr_w), .mode(mode_w), .icnt(icnt_w)
  );

  adc_scan_ctrl #(.CH_W(CH_W), .ICNT_W(ICNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_up(mode_w.dir_up), .pace_en(mode_w.pace_en),
    .int_mode(mode_w.int_mode), .scan_en(scan_en_w), .scan_start(scan_start_w),
    .hi_chan(hi_chan_w), .icnt(icnt_w), .sw_conv(sw_conv_w), .clr(clr_w),
    .conv_tick(conv_tick), .scan_tick(scan_tick), .adc_done(adc_done),
    .adc_start(adc_start), .adc_chan(adc_chan), .busy(busy_w), .ovr(ovr_w), .push(push_w)
  );

  adc_scan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_w), .din(adc_data),
    .rd_byte(rd_en && rd_sel), .clr(clr_w), .dout(fifo_byte),
    .dav(dav_w), .hf(hf_w), .ovf(ovf_w)
  );

  assign rd_data = rd_sel ? fifo_byte : {3'b000, busy_w, ovr_w, ovf_w, hf_w, dav_w};
  assign irq = (mode_w.dav_ie && dav_w) || (mode_w.hf_ie && hf_w) ||
               (mode_w.err_ie && (ovf_w || ovr_w));
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_start,
  input logic [CH_W-1:0] adc_chan,
  input logic            scan_en,
  input logic [CH_W-1:0] hi_chan,
  input logic            busy,
  input logic            dav,
  input logic            hf,
  input logic            ovf,
  input logic            ovr,
  input logic            clr,
  input logic            irq
);
  p_chan_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && scan_en) |-> (adc_chan <= hi_chan));
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);
  p_hf_has_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hf |-> dav);
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  p_ovr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr) |=> ovr);
  p_irq_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(dav || hf || ovf || ovr) |-> !irq);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_chan(adc_chan),
  .scan_en(scan_en_w), .hi_chan(hi_chan_w), .busy(busy_w), .dav(dav_w),
  .hf(hf_w), .ovf(ovf_w), .ovr(ovr_w), .clr(clr_w), .irq(irq)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr_en, rd_en, rd_sel, conv_tick, scan_tick, adc_done, adc_start, irq;
  logic [2:0]  wr_addr, adc_chan;
  logic [7:0]  wr_data, rd_data;
  logic [11:0] adc_data;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .conv_tick(conv_tick),
    .scan_tick(scan_tick), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_data(adc_data), .irq(irq)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  int nlog = 0;
  int chlog [256];
  int mcnt = 0;

  // converter model: result three falling edges after the start pulse
  always @(negedge clk) begin
    adc_done = 1'b0;
    if (mcnt > 0) begin
      mcnt = mcnt - 1;
      if (mcnt == 0) adc_done = 1'b1;
    end
    if (adc_start && rst_n) begin
      chlog[nlog] = int'(adc_chan);
      adc_data = 12'((int'(adc_chan) << 8) | ((nlog + 'h30) & 'hFF));
      nlog = nlog + 1;
      mcnt = 3;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    @(negedge clk); rd_en = 1'b1; rd_sel = sel;
    #1 v = int'(rd_data);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctick();
    @(negedge clk); conv_tick = 1'b1;
    @(negedge clk); conv_tick = 1'b0;
    idle(7);
  endtask

  task automatic stick();
    @(negedge clk); scan_tick = 1'b1;
    @(negedge clk); scan_tick = 1'b0;
    idle(2);
  endtask

  task automatic sample(output int lo, output int hi);
    rd(1'b1, lo);
    rd(1'b1, hi);
  endtask

  initial begin
    int v, lo, hi, base;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; rd_sel = 0; conv_tick = 0; scan_tick = 0;
    wr_addr = '0; wr_data = '0; adc_done = 0; adc_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(1'b0, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 no start", nlog, 0);

    // R3 scan bit without arming is ignored; R2 software start on channel 0
    wr(3'd0, 8'h0B);
    wr(3'd4, 8'h00); idle(8);
    chk("R2 sw start count", nlog, 1);
    chk("R3 unarmed write ignored, chan", chlog[0], 0);
    sample(lo, hi);
    chk("R9 low byte", lo, 'h30);
    chk("R9 high byte", hi, 0);

    wr(3'd0, 8'h05);
    wr(3'd4, 8'h00); idle(8);
    chk("R2 sw start chan", chlog[1], 5);
    rd(1'b0, v); chk("R10 dav set", v & 1, 1);
    sample(lo, hi);
    chk("R9 low byte", lo, 'h31);
    chk("R9 high byte", hi, 5);
    rd(1'b0, v); chk("R10 dav clear after pop", v, 0);

    // R2 software strobe ignored while pacing is on
    wr(3'd1, 8'h02);
    wr(3'd4, 8'h00); idle(8);
    chk("R2 strobe ignored when paced", nlog, 2);

    // R4 / R5 / R6 sweep over every top channel and both directions
    for (int dir = 0; dir < 2; dir++) begin
      for (int top = 1; top < 8; top++) begin
        wr(3'd5, 8'h00);
        wr(3'd1, 8'(8'h02 | dir));
        wr(3'd0, 8'(top));
        wr(3'd0, 8'h08);
        base = nlog;
        for (int k = 0; k < top + 3; k++) ctick();
        chk("R6 one start per tick", nlog - base, top + 3);
        rd(1'b0, v);
        chk("R10 half-full level", (v >> 1) & 1, (top + 3 >= 8) ? 1 : 0);
        for (int k = 0; k < top + 3; k++) begin
          int e;
          e = dir ? (k % (top + 1)) : (top - (k % (top + 1)));
          chk(dir ? "R4 up order" : "R5 down order", chlog[base + k], e);
          sample(lo, hi);
          chk("R9 sample channel", hi, e);
          chk("R9 sample index", lo, (base + k + 'h30) & 'hFF);
        end
      end
    end

    // R8 staged count inactive until strobe; R7 bursts
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h04);
    wr(3'd2, 8'h03);
    base = nlog;
    stick();
    for (int k = 0; k < 5; k++) ctick();
    chk("R8 count not active before strobe", nlog - base, 0);
    wr(3'd3, 8'h00);
    stick();
    for (int k = 0; k < 5; k++) ctick();
    chk("R7 burst length", nlog - base, 3);
    stick();
    for (int k = 0; k < 5; k++) ctick();
    chk("R7 second burst", nlog - base, 6);
    chk("R7 burst channel", chlog[nlog - 1], 2);

    // R12 overrun, R13 error interrupt
    wr(3'd5, 8'h00);
    wr(3'd1, 8'h42);
    wr(3'd0, 8'h01);
    base = nlog;
    @(negedge clk); conv_tick = 1'b1;
    @(negedge clk);
    @(negedge clk); conv_tick = 1'b0;
    idle(8);
    chk("R12 busy tick starts nothing", nlog - base, 1);
    rd(1'b0, v); chk("R12 overrun set", (v >> 3) & 1, 1);
    chk("R13 error irq", int'(irq), 1);
    idle(5);
    rd(1'b0, v); chk("R12 overrun sticky", (v >> 3) & 1, 1);
    wr(3'd5, 8'h00);
    rd(1'b0, v); chk("R11 clear empties and clears errors", v, 0);
    chk("R13 irq after clear", int'(irq), 0);

    // R13 per-source enables
    wr(3'd1, 8'h20);
    wr(3'd4, 8'h00); idle(8);
    chk("R13 hf enable without hf", int'(irq), 0);
    wr(3'd1, 8'h10);
    chk("R13 dav enable", int'(irq), 1);

    // R11 overflow, R10 half-full threshold
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h00);
    base = nlog;
    for (int k = 0; k < 17; k++) begin
      wr(3'd4, 8'h00); idle(6);
      if (k == 6) begin rd(1'b0, v); chk("R10 hf below half", (v >> 1) & 1, 0); end
      if (k == 7) begin rd(1'b0, v); chk("R10 hf at half", (v >> 1) & 1, 1); end
    end
    rd(1'b0, v); chk("R11 overflow status", v & 7, 7);
    sample(lo, hi);
    chk("R11 oldest kept", lo, (base + 'h30) & 'hFF);
    rd(1'b0, v); chk("R11 overflow sticky", (v >> 2) & 1, 1);
    wr(3'd5, 8'h00);
    rd(1'b0, v); chk("R11 cleared", v, 0);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule